// File: doc/BRIEF.md
# GPIO Port Drive and Interrupt Controller

This block manages one I/O port of up to eight pins. For each pin it holds a 3-bit drive mode and the level to drive. It turns the two into pad controls: pull-up and pull-down enables at strong or weak strength, and enables for the input and output buffers. Two override masks can switch off the input buffer or the output buffer of any pin, whatever its mode. Two more per-pin bits, a threshold select and a slew select, go straight to the pad. The analog pad circuitry behind them is outside this block.

Raw pad inputs pass through a two-flop synchroniser. The synchronised level can be read back as the pin state. The block also watches it for edges: each pin can flag rising edges, falling edges, both or neither. A flagged edge sets a sticky status bit, and any set status bit raises the single port interrupt. Software clears status bits by writing ones to them.

Software reaches every field through a simple register port: a write strobe with address and data, and a read port that returns data in the same cycle from the address alone. The port is always ready, so a write completes in the cycle its strobe is high and there is no back-pressure. The pad inputs are sampled every cycle without a handshake. While reset is high, every pin is forced off whatever its stored settings.

Top module: `gpio_port_ctrl`

## Requirements
- R1: While `rst` is high, all pull controls and both buffer enables of every pin are 0, without waiting for a clock edge. After reset, every register reads 0: drive mode 0, output data, override masks, threshold, slew, edge selects and status.
- R2: The drive mode of pin i is bits [3i+2:3i] at address 2. With d the pin's output-data bit (address 0), the modes behave as follows:
  - Mode 0: all controls off.
  - Mode 1: input buffer only.
  - Mode 2: weak pull-up when d=1, strong pull-down when d=0.
  - Mode 3: strong pull-up when d=1, weak pull-down when d=0.
  - Mode 6: strong pull-up or strong pull-down, following d.
  - Mode 7: weak pull-up or weak pull-down, following d.
  - Modes 2 to 7 enable both buffers.
- R3: Mode 4 gives a strong pull-down when d=0 and no pull at all when d=1. Mode 5 gives a strong pull-up when d=1 and no pull at all when d=0.
- R4: A 1 in bit i at address 3 turns off the input buffer of pin i in every mode, and changes no other control of that pin.
- R5: A 1 in bit i at address 4 turns off the output buffer and all four pull controls of pin i in every mode, and leaves its input buffer as the mode sets it.
- R6: Bit i at address 5 appears on `pad_thresh_ttl[i]`, and bit i at address 6 appears on `pad_slew_slow[i]`.
- R7: Address 1 returns the pad input as it was two clock edges earlier. Address 0 reads back the output data as written.
- R8: The edge select of pin i is bits [2i+1:2i] at address 7: 0 none, 1 rising, 2 falling, 3 both. A selected edge of the synchronised level sets status bit i at address 8. The bit stays set until it is cleared.
- R9: Writing address 8 clears each status bit whose data bit is 1 and keeps the others. If an edge sets a bit in the same cycle that a write clears it, the bit stays set.
- R10: `port_irq` is 1 exactly when at least one status bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; also forces the pad controls off |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for reads and writes |
| reg_wdata | input | 3*PINS | Write data |
| reg_rdata | output | 3*PINS | Read data for `reg_addr`, combinational |
| pad_in | input | PINS | Raw pad input levels |
| pad_pu_strong | output | PINS | Strong pull-up enable per pin |
| pad_pu_weak | output | PINS | Weak pull-up enable per pin |
| pad_pd_strong | output | PINS | Strong pull-down enable per pin |
| pad_pd_weak | output | PINS | Weak pull-down enable per pin |
| pad_ibuf_en | output | PINS | Input buffer enable per pin |
| pad_obuf_en | output | PINS | Output buffer enable per pin |
| pad_thresh_ttl | output | PINS | Input threshold select per pin |
| pad_slew_slow | output | PINS | Slew rate select per pin |
| port_irq | output | 1 | Port interrupt request |

## Verification
The bench checks every pin against all eight modes with random data and random override masks. This catches a decoder that drives the opposite level in the open-drain modes, or that lets an override mask leak into the wrong control. Reset is raised in the middle of a run with strong drive configured, so outputs that waited for a clock edge would show drive during the reset cycle. The bench samples the pin state one edge after a change and again two edges after it, which exposes a synchroniser that is one stage short or one stage long. Last, a status clear is lined up with the cycle in which an edge sets the same bit; a design that lets the clear win would lose that interrupt.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [2:0] {
    DM_ANALOG  = 3'd0,
    DM_INPUT   = 3'd1,
    DM_WPU_SPD = 3'd2,
    DM_SPU_WPD = 3'd3,
    DM_OD_LOW  = 3'd4,
    DM_OD_HIGH = 3'd5,
    DM_STRONG  = 3'd6,
    DM_WEAK    = 3'd7
  } drive_mode_e;

  typedef struct packed {
    logic pu_s;
    logic pu_w;
    logic pd_s;
    logic pd_w;
    logic ibuf;
    logic obuf;
  } pad_ctrl_t;

  localparam logic [3:0] RA_DOUT    = 4'd0;
  localparam logic [3:0] RA_PIN     = 4'd1;
  localparam logic [3:0] RA_MODE    = 4'd2;
  localparam logic [3:0] RA_IN_OFF  = 4'd3;
  localparam logic [3:0] RA_OUT_OFF = 4'd4;
  localparam logic [3:0] RA_THRESH  = 4'd5;
  localparam logic [3:0] RA_SLEW    = 4'd6;
  localparam logic [3:0] RA_EDGE    = 4'd7;
  localparam logic [3:0] RA_STAT    = 4'd8;

endpackage

// File: rtl/gpio_drive_decode.sv
module gpio_drive_decode
  import gpio_port_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3*PINS-1:0] mode_flat,
  input  logic [PINS-1:0]   dout,
  input  logic [PINS-1:0]   in_off,
  input  logic [PINS-1:0]   out_off,
  input  logic              force_off,
  output logic [PINS-1:0]   pu_s,
  output logic [PINS-1:0]   pu_w,
  output logic [PINS-1:0]   pd_s,
  output logic [PINS-1:0]   pd_w,
  output logic [PINS-1:0]   ibuf,
  output logic [PINS-1:0]   obuf
);

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    drive_mode_e m;
    logic        d;
    pad_ctrl_t   c;

    assign m = drive_mode_e'(mode_flat[3*i +: 3]);
    assign d = dout[i];

    always_comb begin
      c = '0;
      case (m)
        DM_ANALOG: c = '0;
        DM_INPUT:  c.ibuf = 1'b1;
        DM_WPU_SPD: begin
          c.ibuf = 1'b1; c.obuf = 1'b1;
          c.pu_w = d;    c.pd_s = ~d;
        end
        DM_SPU_WPD: begin
          c.ibuf = 1'b1; c.obuf = 1'b1;
          c.pu_s = d;    c.pd_w = ~d;
        end
        DM_OD_LOW: begin
          c.ibuf = 1'b1; c.obuf = 1'b1;
          c.pd_s = ~d;
        end
        DM_OD_HIGH: begin
          c.ibuf = 1'b1; c.obuf = 1'b1;
          c.pu_s = d;
        end
        DM_STRONG: begin
          c.ibuf = 1'b1; c.obuf = 1'b1;
          c.pu_s = d;    c.pd_s = ~d;
        end
        DM_WEAK: begin
          c.ibuf = 1'b1; c.obuf = 1'b1;
          c.pu_w = d;    c.pd_w = ~d;
        end
      endcase
      if (in_off[i]) c.ibuf = 1'b0;
      if (out_off[i]) begin
        c.obuf = 1'b0;
        c.pu_s = 1'b0; c.pu_w = 1'b0;
        c.pd_s = 1'b0; c.pd_w = 1'b0;
      end
      if (force_off) c = '0;
    end

    assign pu_s[i] = c.pu_s;
    assign pu_w[i] = c.pu_w;
    assign pd_s[i] = c.pd_s;
    assign pd_w[i] = c.pd_w;
    assign ibuf[i] = c.ibuf;
    assign obuf[i] = c.obuf;

    // R2: a pin never pulls both ways, nor at two strengths at once
    a_r2_single_pull: assert property (@(posedge clk) disable iff (rst)
      $countones({pu_s[i], pu_w[i], pd_s[i], pd_w[i]}) <= 1);

    // R3: open drain low never pulls up, open drain high never pulls down
    a_r3_od_low_no_pullup: assert property (@(posedge clk) disable iff (rst)
      (mode_flat[3*i +: 3] == 3'd4) |-> !(pu_s[i] || pu_w[i]));
    a_r3_od_high_no_pulldown: assert property (@(posedge clk) disable iff (rst)
      (mode_flat[3*i +: 3] == 3'd5) |-> !(pd_s[i] || pd_w[i]));

    // R5: output override silences every pull
    a_r5_out_off_quiet: assert property (@(posedge clk) disable iff (rst)
      out_off[i] |-> !(obuf[i] || pu_s[i] || pu_w[i] || pd_s[i] || pd_w[i]));
  end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int PINS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PINS-1:0]   pad_in,
  input  logic [2*PINS-1:0] edge_sel,
  output logic [PINS-1:0]   pin_state,
  output logic [PINS-1:0]   edge_hit
);

  logic [PINS-1:0] s1_q, s2_q, prev_q;

  always_ff @(posedge clk) begin
    s1_q   <= pad_in;
    s2_q   <= s1_q;
    prev_q <= s2_q;
  end

  assign pin_state = s2_q;

  for (genvar i = 0; i < PINS; i++) begin : g_edge
    logic rise, fall;
    assign rise = s2_q[i] & ~prev_q[i];
    assign fall = ~s2_q[i] & prev_q[i];
    assign edge_hit[i] = (edge_sel[2*i] & rise) | (edge_sel[2*i+1] & fall);
  end

  // R7: the pin state trails the pad by exactly two edges
  a_r7_two_stage: assert property (@(posedge clk) disable iff (rst)
    1'b1 |-> ##2 (pin_state == $past(pad_in, 2)));

endmodule

// File: rtl/gpio_irq_stat.sv
module gpio_irq_stat #(
  parameter int PINS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PINS-1:0] edge_hit,
  input  logic            clr_we,
  input  logic [PINS-1:0] clr_mask,
  output logic [PINS-1:0] stat,
  output logic            irq
);

  logic [PINS-1:0] stat_q;
  logic [PINS-1:0] clr_eff;

  assign clr_eff = clr_we ? clr_mask : '0;

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= (stat_q & ~clr_eff) | edge_hit;
  end

  assign stat = stat_q;
  assign irq  = |stat_q;

  // R9: an edge always lands, even against a clear
  a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
    (edge_hit != '0) |=> ((stat_q & $past(edge_hit)) == $past(edge_hit)));

  // R8: status bits stay set without a clear
  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    !clr_we |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [3:0]        reg_addr,
  input  logic [3*PINS-1:0] reg_wdata,
  output logic [3*PINS-1:0] reg_rdata,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   pad_pu_strong,
  output logic [PINS-1:0]   pad_pu_weak,
  output logic [PINS-1:0]   pad_pd_strong,
  output logic [PINS-1:0]   pad_pd_weak,
  output logic [PINS-1:0]   pad_ibuf_en,
  output logic [PINS-1:0]   pad_obuf_en,
  output logic [PINS-1:0]   pad_thresh_ttl,
  output logic [PINS-1:0]   pad_slew_slow,
  output logic              port_irq
);

  localparam int MODE_W = 3 * PINS;
  localparam int EDGE_W = 2 * PINS;

  logic [PINS-1:0]   dout_q, in_off_q, out_off_q, thr_q, slew_q;
  logic [MODE_W-1:0] mode_q;
  logic [EDGE_W-1:0] edge_q;
  logic [PINS-1:0]   pin_state, edge_hit, stat;
  logic              stat_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q    <= '0;
      mode_q    <= '0;
      in_off_q  <= '0;
      out_off_q <= '0;
      thr_q     <= '0;
      slew_q    <= '0;
      edge_q    <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        RA_DOUT:    dout_q    <= reg_wdata[PINS-1:0];
        RA_MODE:    mode_q    <= reg_wdata[MODE_W-1:0];
        RA_IN_OFF:  in_off_q  <= reg_wdata[PINS-1:0];
        RA_OUT_OFF: out_off_q <= reg_wdata[PINS-1:0];
        RA_THRESH:  thr_q     <= reg_wdata[PINS-1:0];
        RA_SLEW:    slew_q    <= reg_wdata[PINS-1:0];
        RA_EDGE:    edge_q    <= reg_wdata[EDGE_W-1:0];
        default: ;
      endcase
    end
  end

  assign stat_we = reg_we && (reg_addr == RA_STAT);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_DOUT:    reg_rdata[PINS-1:0]   = dout_q;
      RA_PIN:     reg_rdata[PINS-1:0]   = pin_state;
      RA_MODE:    reg_rdata[MODE_W-1:0] = mode_q;
      RA_IN_OFF:  reg_rdata[PINS-1:0]   = in_off_q;
      RA_OUT_OFF: reg_rdata[PINS-1:0]   = out_off_q;
      RA_THRESH:  reg_rdata[PINS-1:0]   = thr_q;
      RA_SLEW:    reg_rdata[PINS-1:0]   = slew_q;
      RA_EDGE:    reg_rdata[EDGE_W-1:0] = edge_q;
      RA_STAT:    reg_rdata[PINS-1:0]   = stat;
      default:    reg_rdata = '0;
    endcase
  end

  gpio_drive_decode #(.PINS(PINS)) u_decode (
    .clk       (clk),
    .rst       (rst),
    .mode_flat (mode_q),
    .dout      (dout_q),
    .in_off    (in_off_q),
    .out_off   (out_off_q),
    .force_off (rst),
    .pu_s      (pad_pu_strong),
    .pu_w      (pad_pu_weak),
    .pd_s      (pad_pd_strong),
    .pd_w      (pad_pd_weak),
    .ibuf      (pad_ibuf_en),
    .obuf      (pad_obuf_en)
  );

  gpio_in_sync #(.PINS(PINS)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .pad_in    (pad_in),
    .edge_sel  (edge_q),
    .pin_state (pin_state),
    .edge_hit  (edge_hit)
  );

  gpio_irq_stat #(.PINS(PINS)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .edge_hit (edge_hit),
    .clr_we   (stat_we),
    .clr_mask (reg_wdata[PINS-1:0]),
    .stat     (stat),
    .irq      (port_irq)
  );

  assign pad_thresh_ttl = thr_q;
  assign pad_slew_slow  = slew_q;

  // R1: reset silences every pad control at once
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |-> (pad_pu_strong == '0 && pad_pu_weak == '0 && pad_pd_strong == '0
             && pad_pd_weak == '0 && pad_ibuf_en == '0 && pad_obuf_en == '0));

  // R10: the port request follows the status register through a clear
  a_r10_irq_drops: assert property (@(posedge clk) disable iff (rst)
    (stat_we && (reg_wdata[PINS-1:0] == {PINS{1'b1}}) && edge_hit == '0) |=> !port_irq);

endmodule

// File: tb/gpio_port_ctrl_test.sv
module gpio_port_ctrl_test;

  localparam int PINS = 8;
  localparam int BW   = 3 * PINS;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            reg_we = 1'b0;
  logic [3:0]      reg_addr = '0;
  logic [BW-1:0]   reg_wdata = '0;
  logic [BW-1:0]   reg_rdata;
  logic [PINS-1:0] pad_in = '0;
  logic [PINS-1:0] pu_s, pu_w, pd_s, pd_w, ibuf, obuf, thr, slew;
  logic            port_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  gpio_port_ctrl #(.PINS(PINS)) uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
    .pad_pu_strong(pu_s), .pad_pu_weak(pu_w), .pad_pd_strong(pd_s),
    .pad_pd_weak(pd_w), .pad_ibuf_en(ibuf), .pad_obuf_en(obuf),
    .pad_thresh_ttl(thr), .pad_slew_slow(slew), .port_irq(port_irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [BW-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [BW-1:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // {pu_s, pu_w, pd_s, pd_w, ibuf, obuf}
  function automatic logic [5:0] exp_pad(input int m, input bit d, input bit ioff, input bit ooff);
    logic [5:0] r;
    case (m)
      0: r = 6'b000000;
      1: r = 6'b000010;
      2: r = {1'b0, d, ~d, 1'b0, 2'b11};
      3: r = {d, 1'b0, 1'b0, ~d, 2'b11};
      4: r = {1'b0, 1'b0, ~d, 1'b0, 2'b11};
      5: r = {d, 1'b0, 1'b0, 1'b0, 2'b11};
      6: r = {d, 1'b0, ~d, 1'b0, 2'b11};
      default: r = {1'b0, d, 1'b0, ~d, 2'b11};
    endcase
    if (ioff) r[1] = 1'b0;
    if (ooff) r = {5'b00000, 1'b0} | {4'b0000, r[1], 1'b0};
    return r;
  endfunction

  function automatic logic [PINS-1:0] edges(input logic [PINS-1:0] old_v, input logic [PINS-1:0] new_v,
                                            input logic [2*PINS-1:0] sel);
    logic [PINS-1:0] h;
    for (int i = 0; i < PINS; i++) begin
      h[i] = (sel[2*i] & ~old_v[i] & new_v[i]) | (sel[2*i+1] & old_v[i] & ~new_v[i]);
    end
    return h;
  endfunction

  task automatic check_pads(input logic [BW-1:0] mode, input logic [PINS-1:0] d,
                            input logic [PINS-1:0] ioff, input logic [PINS-1:0] ooff);
    for (int i = 0; i < PINS; i++) begin
      int m;
      string tag;
      logic [5:0] e;
      m = int'(mode[3*i +: 3]);
      e = exp_pad(m, d[i], ioff[i], ooff[i]);
      if (ooff[i]) tag = "R5 output override";
      else if (ioff[i]) tag = "R4 input override";
      else if (m == 4 || m == 5) tag = "R3 open drain";
      else tag = "R2 mode decode";
      chk(tag, {26'd0, pu_s[i], pu_w[i], pd_s[i], pd_w[i], ibuf[i], obuf[i]}, {26'd0, e});
    end
  endtask

  initial begin : watchdog
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [BW-1:0] rv;
    logic [BW-1:0] mode;
    logic [PINS-1:0] d, ioff, ooff, t, s, np, exp_stat, prev, mask;
    logic [2*PINS-1:0] esel;
    void'($urandom(32'd1234));

    // R1: pads quiet during reset, before and after clock edges
    pad_in = 8'hA5;
    #1;
    chk("R1 reset drive", {8'd0, pu_s, pu_w, pd_s, pd_w}, 32'd0);
    chk("R1 reset buffers", {16'd0, ibuf, obuf}, 32'd0);
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    rd(RA_DOUT_T(), rv);  chk("R1 dout default", 32'(rv), 32'd0);
    rd(4'd2, rv);         chk("R1 mode default", 32'(rv), 32'd0);
    rd(4'd7, rv);         chk("R1 edge default", 32'(rv), 32'd0);
    rd(4'd8, rv);         chk("R1 status default", 32'(rv), 32'd0);
    chk("R1 analog after reset", {16'd0, ibuf, obuf}, 32'd0);

    // R2 R3 R4 R5 R6: random decode
    for (int it = 0; it < 60; it++) begin
      mode = BW'($urandom);
      d    = PINS'($urandom);
      ioff = PINS'($urandom) & PINS'($urandom);
      ooff = PINS'($urandom) & PINS'($urandom);
      t    = PINS'($urandom);
      s    = PINS'($urandom);
      wr(4'd2, mode);
      wr(4'd0, BW'(d));
      wr(4'd3, BW'(ioff));
      wr(4'd4, BW'(ooff));
      wr(4'd5, BW'(t));
      wr(4'd6, BW'(s));
      #1;
      check_pads(mode, d, ioff, ooff);
      chk("R6 threshold", 32'(thr), 32'(t));
      chk("R6 slew", 32'(slew), 32'(s));
      rd(4'd0, rv); chk("R7 dout readback", 32'(rv), 32'(d));
    end

    // R3 directed: open drain on undriven level pulls nothing
    wr(4'd3, '0);
    wr(4'd4, '0);
    wr(4'd2, {PINS{3'd4}});
    wr(4'd0, BW'({PINS{1'b1}}));
    #1;
    chk("R3 od low released", {24'd0, pu_s | pu_w | pd_s | pd_w}, 32'd0);
    chk("R3 od low buffers", {16'd0, ibuf, obuf}, 32'h0000FFFF);
    wr(4'd2, {PINS{3'd5}});
    wr(4'd0, '0);
    #1;
    chk("R3 od high released", {24'd0, pu_s | pu_w | pd_s | pd_w}, 32'd0);

    // R1: reset mid-run with strong drive configured
    wr(4'd2, {PINS{3'd6}});
    wr(4'd0, BW'(8'h3C));
    #1;
    chk("R1 pre-reset strong", {16'd0, pu_s, pd_s}, 32'h3CC3);
    @(negedge clk);
    rst = 1'b1;
    #1;
    chk("R1 immediate quiet", {8'd0, pu_s, pu_w, pd_s, pd_w}, 32'd0);
    chk("R1 immediate buffers", {16'd0, ibuf, obuf}, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    #1;
    rd(4'd2, rv); chk("R1 mode cleared", 32'(rv), 32'd0);

    // R7: pin state latency
    pad_in = 8'h00;
    repeat (4) @(negedge clk);
    pad_in = 8'h5A;
    @(negedge clk);
    rd(4'd1, rv); chk("R7 one edge old", 32'(rv), 32'h00);
    @(negedge clk);
    rd(4'd1, rv); chk("R7 two edges new", 32'(rv), 32'h5A);
    for (int it = 0; it < 20; it++) begin
      np = PINS'($urandom);
      pad_in = np;
      repeat (3) @(negedge clk);
      rd(4'd1, rv); chk("R7 pin state", 32'(rv), 32'(np));
    end

    // R8 R9 R10: random edges
    esel = (2*PINS)'($urandom);
    wr(4'd7, BW'(esel));
    wr(4'd8, BW'({PINS{1'b1}}));
    #1;
    exp_stat = '0;
    prev = pad_in;
    rd(4'd8, rv); chk("R9 cleared", 32'(rv), 32'd0);
    chk("R10 irq low", 32'(port_irq), 32'd0);
    for (int it = 0; it < 50; it++) begin
      np = PINS'($urandom);
      @(negedge clk);
      pad_in = np;
      repeat (3) @(posedge clk);
      @(negedge clk);
      exp_stat = exp_stat | edges(prev, np, esel);
      prev = np;
      rd(4'd8, rv); chk("R8 status", 32'(rv), 32'(exp_stat));
      chk("R10 irq", 32'(port_irq), 32'(|exp_stat));
      if (it % 5 == 4) begin
        mask = PINS'($urandom);
        wr(4'd8, BW'(mask));
        #1;
        exp_stat = exp_stat & ~mask;
        rd(4'd8, rv); chk("R9 w1c", 32'(rv), 32'(exp_stat));
        chk("R10 irq after clear", 32'(port_irq), 32'(|exp_stat));
      end
      if (it == 25) begin
        esel = (2*PINS)'($urandom);
        wr(4'd7, BW'(esel));
      end
    end

    // R9 directed: set wins over simultaneous clear
    wr(4'd7, BW'(2'b01));
    pad_in = '0;
    repeat (4) @(negedge clk);
    wr(4'd8, BW'({PINS{1'b1}}));
    #1;
    rd(4'd8, rv); chk("R9 pre clear", 32'(rv), 32'd0);
    @(negedge clk);
    pad_in = 8'h01;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 4'd8; reg_wdata = BW'(1);
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
    rd(4'd8, rv); chk("R9 set beats clear", 32'(rv), 32'd1);
    chk("R10 irq raised", 32'(port_irq), 32'd1);
    wr(4'd8, BW'(1));
    #1;
    rd(4'd8, rv); chk("R9 later clear", 32'(rv), 32'd0);
    chk("R10 irq dropped", 32'(port_irq), 32'd0);

    // R8: rising-only pin ignores a falling edge
    @(negedge clk);
    pad_in = 8'h00;
    repeat (4) @(negedge clk);
    rd(4'd8, rv); chk("R8 falling ignored", 32'(rv), 32'd0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  function automatic logic [3:0] RA_DOUT_T();
    return 4'd0;
  endfunction

endmodule